// File: doc/BRIEF.md
# Memory-Mapped Serial Transmitter

This block is the sending half of a simple serial port that sits behind a 32-bit register window. Software drops characters into an eight-entry queue by writing the data register. Before each write it polls a full flag in bit 31 of that same register. A serializer drains the queue one character at a time. It drives a single output line with frames of one start bit, eight data bits least-significant first, and one or two stop bits. Each bit lasts divisor + 1 clock cycles.

A watermark interrupt tells software that the queue has room. The pending condition holds while the number of queued characters is below a programmable three-bit level, and the interrupt output is that condition gated by an enable bit. When the transmitter is switched off, no new frame starts. The queue keeps its contents and the line rests high.

Top module: `mmio_tx_port`

## Requirements
- R1: After reset, every register reads zero, `tx_line` is high and `tx_irq` is low.
- R2: Register offsets and fields: control at 0x08 has bit 0 = transmitter on, bit 1 = two stop bits, bits 18:16 = watermark level. Interrupt enable at 0x10 uses bit 0. The divisor at 0x18 occupies bits DIV_W-1:0. Each field reads back as written and all other bits read zero. Offsets 0x04 and 0x0C read zero. A write to 0x14 changes nothing.
- R3: A write to offset 0x00 queues its low 8 bits in an 8-entry FIFO. A write while the FIFO is full is dropped and never appears on the line.
- R4: A read of offset 0x00 returns bit 31 set exactly while the FIFO holds 8 entries, with every other bit zero.
- R5: Bit 0 of offset 0x14 reads 1 exactly while the FIFO entry count is strictly below the watermark level. `tx_irq` equals that bit ANDed with interrupt-enable bit 0.
- R6: With the transmitter off, no frame starts, the FIFO keeps its contents and `tx_line` stays high. With it on and the serializer idle, a queued character starts its frame on the next clock edge.
- R7: A frame is a low start bit, then eight data bits least-significant first, then high stop bits. Every bit lasts divisor + 1 clock cycles.
- R8: The frame carries two stop bits when control bit 1 is set and one when it is clear. The setting is captured when the frame starts. With characters waiting, successive start bits begin (9 + stop bits) x (divisor + 1) + 1 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the offset |
| tx_line | output | 1 | Serial output, idles high |
| tx_irq | output | 1 | Watermark interrupt |

## Verification
Several properties are checked on every cycle by the assertions. The FIFO count never exceeds its depth and does not change on a write to a full queue. Nothing leaves the queue while the transmitter is off. The line is high whenever the serializer is idle and low during the start bit. The line cannot change partway through a bit period. The interrupt never rises without its enable. Other behaviours are shown only by the bench scenarios. These are the exact data bits and their order on the line, the spacing between frames for each divisor and stop setting, the watermark comparison across every level and fill count, and the fact that a dropped write never reaches the line.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  localparam logic [4:0] OFS_DATA  = 5'h00;
  localparam logic [4:0] OFS_CTRL  = 5'h08;
  localparam logic [4:0] OFS_IEN   = 5'h10;
  localparam logic [4:0] OFS_IPEND = 5'h14;
  localparam logic [4:0] OFS_DIV   = 5'h18;

  localparam int WM_LSB = 16;

  typedef enum logic [1:0] {
    SER_IDLE  = 2'd0,
    SER_START = 2'd1,
    SER_DATA  = 2'd2,
    SER_STOP  = 2'd3
  } ser_state_e;
endpackage

// File: rtl/mtx_regs.sv
module mtx_regs
  import mtx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int WM_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [4:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  input  logic             fifo_full,
  input  logic             wm_pend,
  output logic [31:0]      bus_rdata,
  output logic             tx_en,
  output logic             two_stop,
  output logic [WM_W-1:0]  wm_lvl,
  output logic             irq_en,
  output logic [DIV_W-1:0] div_val,
  output logic             push_req,
  output logic [7:0]       push_byte
);
  logic             en_q, en_d;
  logic             stop_q, stop_d;
  logic [WM_W-1:0]  wm_q, wm_d;
  logic             ie_q, ie_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             wr_hit;
  logic             unused_wbits;

  assign wr_hit       = bus_sel & bus_wr;
  assign unused_wbits = ^bus_wdata;

  // next-state for configuration registers
  always_comb begin
    en_d   = en_q;
    stop_d = stop_q;
    wm_d   = wm_q;
    ie_d   = ie_q;
    div_d  = div_q;
    if (wr_hit) begin
      case (bus_addr)
        OFS_CTRL: begin
          en_d   = bus_wdata[0];
          stop_d = bus_wdata[1];
          wm_d   = bus_wdata[WM_LSB +: WM_W];
        end
        OFS_IEN: ie_d  = bus_wdata[0];
        OFS_DIV: div_d = bus_wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      stop_q <= 1'b0;
      wm_q   <= '0;
      ie_q   <= 1'b0;
      div_q  <= '0;
    end else if (wr_hit) begin
      en_q   <= en_d;
      stop_q <= stop_d;
      wm_q   <= wm_d;
      ie_q   <= ie_d;
      div_q  <= div_d;
    end
  end

  assign push_req  = wr_hit && (bus_addr == OFS_DATA);
  assign push_byte = bus_wdata[7:0];

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        OFS_DATA:  bus_rdata[31] = fifo_full;
        OFS_CTRL: begin
          bus_rdata[0]               = en_q;
          bus_rdata[1]               = stop_q;
          bus_rdata[WM_LSB +: WM_W]  = wm_q;
        end
        OFS_IEN:   bus_rdata[0] = ie_q;
        OFS_IPEND: bus_rdata[0] = wm_pend;
        OFS_DIV:   bus_rdata[DIV_W-1:0] = div_q;
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign tx_en    = en_q;
  assign two_stop = stop_q;
  assign wm_lvl   = wm_q;
  assign irq_en   = ie_q;
  assign div_val  = div_q;

  // R2: a write to the pending offset leaves all configuration unchanged
  a_r2_pend_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == OFS_IPEND) |=>
      ($stable(en_q) && $stable(stop_q) && $stable(wm_q) && $stable(ie_q) && $stable(div_q)));
endmodule

// File: rtl/mtx_fifo.sv
module mtx_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CMAX);
  assign empty   = (cnt_q == '0);
  assign do_push = push_req & ~full;
  assign do_pop  = pop & ~empty;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (!do_push && do_pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_data;
  end

  assign head  = mem[rp_q];
  assign count = cnt_q;

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CMAX);

  a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && !pop) |=> (cnt_q == CMAX));

  a_r3_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && push_req && !pop) |=> (cnt_q == CW'(1)));
endmodule

// File: rtl/mtx_ser.sv
module mtx_ser
  import mtx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             two_stop,
  input  logic [DIV_W-1:0] div_val,
  input  logic             fifo_empty,
  input  logic [7:0]       fifo_head,
  output logic             pop,
  output logic             line
);
  ser_state_e       st_q, st_d;
  logic [DIV_W-1:0] baud_q, baud_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d;
  logic             st2_q, st2_d;
  logic             line_q, line_d;
  logic             tick;

  assign tick = (baud_q >= div_val);

  always_comb begin
    st_d   = st_q;
    baud_d = baud_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    st2_d  = st2_q;
    line_d = line_q;
    pop    = 1'b0;
    case (st_q)
      SER_IDLE: begin
        line_d = 1'b1;
        if (tx_en && !fifo_empty) begin
          pop    = 1'b1;
          sh_d   = fifo_head;
          st2_d  = two_stop;
          baud_d = '0;
          line_d = 1'b0;
          st_d   = SER_START;
        end
      end
      SER_START: begin
        if (tick) begin
          baud_d = '0;
          bit_d  = '0;
          line_d = sh_q[0];
          st_d   = SER_DATA;
        end else begin
          baud_d = baud_q + 1'b1;
        end
      end
      SER_DATA: begin
        if (tick) begin
          baud_d = '0;
          if (bit_q == 3'd7) begin
            line_d = 1'b1;
            st_d   = SER_STOP;
          end else begin
            bit_d  = bit_q + 1'b1;
            sh_d   = sh_q >> 1;
            line_d = sh_q[1];
          end
        end else begin
          baud_d = baud_q + 1'b1;
        end
      end
      SER_STOP: begin
        if (tick) begin
          baud_d = '0;
          if (st2_q) st2_d = 1'b0;
          else       st_d  = SER_IDLE;
        end else begin
          baud_d = baud_q + 1'b1;
        end
      end
      default: st_d = SER_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SER_IDLE;
      baud_q <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      st2_q  <= 1'b0;
      line_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      baud_q <= baud_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      st2_q  <= st2_d;
      line_q <= line_d;
    end
  end

  assign line = line_q;

  a_r6_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SER_IDLE) |-> line_q);

  a_r7_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SER_START) |-> !line_q);

  a_r7_bit_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_q != '0) |-> $stable(line_q));

  a_r8_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SER_STOP) |-> line_q);
endmodule

// File: rtl/mmio_tx_port.sv
module mmio_tx_port #(
  parameter int DEPTH = 8,
  parameter int DIV_W = 16,
  parameter int WM_W  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tx_line,
  output logic        tx_irq
);
  localparam int CW = $clog2(DEPTH + 1);

  logic             rs_a, rs_b;
  logic             tx_en, two_stop, irq_en, push_req, pop;
  logic [WM_W-1:0]  wm_lvl;
  logic [DIV_W-1:0] div_val;
  logic [7:0]       push_byte, head;
  logic             f_empty, f_full, wm_pend;
  logic [CW-1:0]    f_cnt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_a <= 1'b0;
      rs_b <= 1'b0;
    end else begin
      rs_a <= 1'b1;
      rs_b <= rs_a;
    end
  end

  mtx_regs #(.DIV_W(DIV_W), .WM_W(WM_W)) u_regs (
    .clk(clk), .rst_n(rs_b),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .fifo_full(f_full), .wm_pend(wm_pend), .bus_rdata(bus_rdata),
    .tx_en(tx_en), .two_stop(two_stop), .wm_lvl(wm_lvl), .irq_en(irq_en),
    .div_val(div_val), .push_req(push_req), .push_byte(push_byte)
  );

  mtx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rs_b),
    .push_req(push_req), .push_data(push_byte), .pop(pop),
    .head(head), .empty(f_empty), .full(f_full), .count(f_cnt)
  );

  mtx_ser #(.DIV_W(DIV_W)) u_ser (
    .clk(clk), .rst_n(rs_b),
    .tx_en(tx_en), .two_stop(two_stop), .div_val(div_val),
    .fifo_empty(f_empty), .fifo_head(head), .pop(pop), .line(tx_line)
  );

  assign wm_pend = ({{(32-CW){1'b0}}, f_cnt} < {{(32-WM_W){1'b0}}, wm_lvl});
  assign tx_irq  = wm_pend & irq_en;

  a_r6_no_pop_when_off: assert property (@(posedge clk) disable iff (!rs_b)
    pop |-> tx_en);

  a_r6_hold_when_off: assert property (@(posedge clk) disable iff (!rs_b)
    !tx_en |=> (f_cnt >= $past(f_cnt)));

  a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rs_b)
    tx_irq |-> irq_en);
endmodule

// File: tb/tb_mmio_tx_port.sv
module tb_mmio_tx_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        tx_line, tx_irq;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  mmio_tx_port dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_line(tx_line), .tx_irq(tx_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rx_frame(input int dv, input int nst, output logic [7:0] b, output int t0);
    int guard = 0;
    @(negedge clk);
    while (tx_line !== 1'b0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    t0 = cyc;
    chk("R6 frame start seen", 32'(guard < 5000), 32'd1);
    repeat (dv/2) @(negedge clk);
    chk("R7 start bit low", 32'(tx_line), 32'd0);
    for (int i = 0; i < 8; i++) begin
      repeat (dv+1) @(negedge clk);
      b[i] = tx_line;
    end
    for (int k = 0; k <= nst; k++) begin
      repeat (dv+1) @(negedge clk);
      chk("R8 stop bit high", 32'(tx_line), 32'd1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [7:0]  got, exp_b;
    int t0, tprev;
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    foreach (r[i]) r[i] = 1'b0;
    for (int a = 0; a < 7; a++) begin
      rd(5'(a*4), r);
      chk("R1 reset register", r, 32'd0);
    end
    chk("R1 reset line", 32'(tx_line), 32'd1);
    chk("R1 reset irq", 32'(tx_irq), 32'd0);

    // R2 field readback and ignored bits
    wr(5'h08, 32'hFFFF_FFFE);
    rd(5'h08, r); chk("R2 control readback", r, 32'h0007_0002);
    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h10, r); chk("R2 enable readback", r, 32'h1);
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h18, r); chk("R2 divisor readback", r, 32'h0000_FFFF);
    rd(5'h04, r); chk("R2 unmapped 0x04", r, 32'h0);
    rd(5'h0C, r); chk("R2 unmapped 0x0C", r, 32'h0);
    wr(5'h08, 32'h0);
    wr(5'h14, 32'hFFFF_FFFF);
    rd(5'h14, r); chk("R2 pending write ignored", r, 32'h0);
    rd(5'h08, r); chk("R2 control after pending write", r, 32'h0);
    chk("R2 line after pending write", 32'(tx_line), 32'd1);
    wr(5'h10, 32'h0);
    wr(5'h18, 32'h0);

    // R4 R5 sweep over every watermark level and fill count
    for (int wm = 0; wm < 8; wm++) begin
      int ie = wm % 2;
      wr(5'h08, 32'(wm) << 16);
      wr(5'h10, 32'(ie));
      for (int n = 0; n <= 8; n++) begin
        rd(5'h14, r); chk("R5 pending vs level", r, 32'(n < wm));
        chk("R5 irq gating", 32'(tx_irq), 32'((n < wm) && ie == 1));
        rd(5'h00, r); chk("R4 full flag", r, (n == 8) ? 32'h8000_0000 : 32'h0);
        if (n < 8) wr(5'h00, 32'(n + 8'hA0));
      end
      wr(5'h08, 32'h1 | (32'(wm) << 16));
      repeat (8*11 + 20) @(negedge clk);
      wr(5'h08, 32'(wm) << 16);
      rd(5'h14, r); chk("R5 pending after drain", r, 32'(wm > 0));
    end
    wr(5'h10, 32'h0);

    // R6 hold with transmitter off, R3 drop when full
    for (int k = 0; k < 8; k++) wr(5'h00, 32'h10 + 32'(k));
    begin
      int hi = 1;
      for (int c = 0; c < 50; c++) begin
        @(negedge clk);
        if (tx_line !== 1'b1) hi = 0;
      end
      chk("R6 line high while off", 32'(hi), 32'd1);
    end
    rd(5'h00, r); chk("R6 fifo held while off", r, 32'h8000_0000);
    wr(5'h00, 32'hEE);
    wr(5'h18, 32'd2);
    wr(5'h08, 32'h1);
    tprev = 0;
    for (int k = 0; k < 8; k++) begin
      rx_frame(2, 0, got, t0);
      chk("R3 queued byte order", 32'(got), 32'h10 + 32'(k));
      if (k > 0) chk("R8 spacing one stop", 32'(t0 - tprev), 32'(10*3 + 1));
      tprev = t0;
    end
    begin
      int hi = 1;
      for (int c = 0; c < 80; c++) begin
        @(negedge clk);
        if (tx_line !== 1'b1) hi = 0;
      end
      chk("R3 dropped write never sent", 32'(hi), 32'd1);
    end
    rd(5'h00, r); chk("R4 not full after drain", r, 32'h0);

    // R7 R8 frame sweep over divisor and stop setting
    for (int di = 0; di < 4; di++) begin
      int dv = (di == 0) ? 0 : (di == 1) ? 1 : (di == 2) ? 3 : 6;
      for (int s = 0; s < 2; s++) begin
        wr(5'h08, 32'h0);
        wr(5'h18, 32'(dv));
        for (int k = 0; k < 4; k++) wr(5'h00, 32'((dv*37 + s*91 + k*53 + 1) & 8'hFF));
        wr(5'h08, 32'h1 | (32'(s) << 1));
        tprev = 0;
        for (int k = 0; k < 4; k++) begin
          exp_b = 8'((dv*37 + s*91 + k*53 + 1) & 8'hFF);
          rx_frame(dv, s, got, t0);
          chk("R7 data bits lsb first", 32'(got), 32'(exp_b));
          if (k > 0) chk("R8 frame spacing", 32'(t0 - tprev), 32'((10 + s)*(dv + 1) + 1));
          tprev = t0;
        end
        repeat (20) @(negedge clk);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule